// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial bus in front of a byte-wide array. The array stands in for nonvolatile cells and is a synchronous RAM. Both bus lines are brought into the system clock domain and oversampled. The block detects start and stop conditions and answers only its own device address. That address is a fixed `1010` type nibble followed by three strap inputs. It serves byte and page writes, current-address reads, random reads and sequential reads. It drives the data line only by pulling it low. An external pull-up or wire-AND makes the bus level.

A write transaction loads a 64-byte staging buffer. The buffer goes into the array only when the master ends the transaction with a stop. After that stop, a self-timed busy window of `BUSY_CYCLES` system clocks stands in for the cell programming time. During that window the block ignores every addressing attempt. A master can therefore poll with an address byte until an acknowledge comes back.

The word address on the bus is 15 bits wide. The array keeps its low `AW` bits: the default of 11 gives 2048 bytes, and 15 gives the full 32768 bytes. When the write-protect input is high, the block still accepts write traffic but keeps none of it. Reads are not affected.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A fall of SDA while SCL is high is a start, and a rise of SDA while SCL is high is a stop. A start aborts any transaction and begins address reception. The block changes its SDA drive only while SCL is low.
- R2: The first byte after a start is accepted only when bits 7..4 equal 1010 and bits 3..1 equal `strap[2:0]`. Bit 0 selects read (1) or write (0). On any mismatch the block leaves SDA released in the ninth clock and ignores the bus until the next start.
- R3: The block acknowledges an accepted device byte, both word-address bytes and every write data byte by driving SDA low (`sda_oe`=1) during the ninth SCL clock. Out of reset `sda_oe` is 0.
- R4: The word address follows a write device byte as two bytes, high byte first. Of its 15 bits the low `AW` bits select the array byte.
- R5: Each data byte of a write increments only the low 6 bits of the address, which is the offset within a 64-byte page. Bytes past offset 63 continue at offset 0 of the same page, so more than 64 bytes overwrite the earliest ones.
- R6: A stop that ends a write with at least one kept data byte commits the staged bytes and opens a busy window of `BUSY_CYCLES` clocks. Every device byte in that window is not acknowledged, and `sda_oe` stays 0. After the window the device byte is acknowledged again.
- R7: The address pointer holds the last accessed address plus one. A read device byte with no word address returns the byte at the pointer. A word-address write followed by a repeated start and a read device byte returns the byte at that word address.
- R8: In a read, the pointer advances after each byte sent and wraps from the last array byte to byte 0. Each master acknowledge (SDA low in the ninth clock) produces the next byte. A master non-acknowledge ends the read.
- R9: While `wp_i` is 1, write data bytes are acknowledged but nothing is kept. The stop opens no busy window, and reads still return the stored data.
- R10: A stop after only the device byte, or after the word address with no data byte, changes no array byte and opens no busy window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| strap | input | 3 | Device select straps compared with address bits 3..1 |
| wp_i | input | 1 | 1 makes the whole array read-only |

## Verification
On every cycle, the embedded properties check four things: the SDA drive never changes while SCL is high, nothing is driven during the busy window, a protected write never opens that window, and a page write never leaves its 64-byte row. They also check that a mismatched device byte falls silent, and that a running read only ever steps its pointer by one modulo the array size. Whether the right bytes land in the right places takes the bench's bus scenarios. These cover the in-page wrap and the overflow past 64 bytes, the array-end wrap of a sequential read, and the pointer left behind for a current-address read. They also cover polling through the busy window and protected writes that leave the data intact.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int AW          = 11,
  parameter int PW          = 6,
  parameter int BUSY_CYCLES = 200
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scl_i,
  input  logic         sda_i,
  output logic         sda_oe,
  input  logic [2:0]   strap,
  input  logic         wp_i
);
  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PW;
  localparam int BW    = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AH, S_AL, S_WR, S_RD} st_t;

  logic [2:0] scl_s, sda_s;
  logic       scl, scl_d, sda, sda_d;
  logic       rise, fall, start, stop;

  st_t              state;
  logic [3:0]       bitcnt;
  logic [7:0]       sr, tx, rd_q;
  logic [6:0]       ahi;
  logic [AW-1:0]    ptr;
  logic [AW-PW-1:0] pg;
  logic [PAGE-1:0]  mask;
  logic             mack, have, busy;
  logic [BW-1:0]    bcnt;
  logic [PW:0]      cidx;
  logic [14:0]      word;
  logic             dev_hit, wr_byte;

  logic [7:0] mem  [DEPTH];
  logic [7:0] pbuf [PAGE];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end

  assign scl   = scl_s[1];
  assign scl_d = scl_s[2];
  assign sda   = sda_s[1];
  assign sda_d = sda_s[2];
  assign rise  = scl & ~scl_d;
  assign fall  = ~scl & scl_d;
  assign start = scl & scl_d & sda_d & ~sda;
  assign stop  = scl & scl_d & ~sda_d & sda;

  assign word    = {ahi, sr};
  assign dev_hit = (sr[7:4] == 4'b1010) && (sr[3:1] == strap) && !busy;
  assign wr_byte = fall && state == S_WR && bitcnt == 4'd8 && !wp_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      sr     <= '0;
      tx     <= '0;
      ahi    <= '0;
      ptr    <= '0;
      pg     <= '0;
      mask   <= '0;
      mack   <= 1'b0;
      have   <= 1'b0;
      busy   <= 1'b0;
      bcnt   <= '0;
      cidx   <= '0;
      sda_oe <= 1'b0;
    end else begin
      if (busy) begin
        bcnt <= bcnt - 1'b1;
        cidx <= cidx + {{PW{1'b0}}, !cidx[PW]};
        if (bcnt == BW'(1)) busy <= 1'b0;
      end
      if (stop) begin
        if (state == S_WR && have && !wp_i) begin
          busy <= 1'b1;
          bcnt <= BW'(BUSY_CYCLES);
          cidx <= '0;
        end
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start) begin
        state  <= S_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (state != S_IDLE) begin
        if (rise) begin
          bitcnt <= bitcnt + 1'b1;
          if (state != S_RD && bitcnt < 4'd8) sr <= {sr[6:0], sda};
          if (state == S_RD && bitcnt == 4'd8) mack <= ~sda;
        end else if (fall) begin
          if (state == S_RD) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              ptr    <= ptr + 1'b1;
            end else if (bitcnt == 4'd9) begin
              if (mack) begin
                tx     <= rd_q;
                sda_oe <= ~rd_q[7];
                bitcnt <= '0;
              end else begin
                state <= S_IDLE;
              end
            end else if (bitcnt != 4'd0) begin
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
            end
          end else if (bitcnt == 4'd8) begin
            case (state)
              S_DEV: if (dev_hit) sda_oe <= 1'b1;
                     else state <= S_IDLE;
              S_AH: begin
                ahi    <= sr[6:0];
                sda_oe <= 1'b1;
              end
              S_AL: begin
                ptr    <= word[AW-1:0];
                pg     <= word[AW-1:PW];
                mask   <= '0;
                have   <= 1'b0;
                sda_oe <= 1'b1;
              end
              S_WR: begin
                sda_oe <= 1'b1;
                ptr    <= {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
                if (!wp_i) begin
                  mask[ptr[PW-1:0]] <= 1'b1;
                  have <= 1'b1;
                end
              end
              default: ;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            sda_oe <= 1'b0;
            case (state)
              S_DEV: if (sr[0]) begin
                       state  <= S_RD;
                       tx     <= rd_q;
                       sda_oe <= ~rd_q[7];
                     end else state <= S_AH;
              S_AH: state <= S_AL;
              S_AL: state <= S_WR;
              default: ;
            endcase
          end
        end
      end
    end

  always_ff @(posedge clk)
    if (wr_byte) pbuf[ptr[PW-1:0]] <= sr;

  always_ff @(posedge clk) begin
    if (busy && !cidx[PW] && mask[cidx[PW-1:0]])
      mem[{pg, cidx[PW-1:0]}] <= pbuf[cidx[PW-1:0]];
    rd_q <= mem[ptr];
  end

  p_oe_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s[1]));

  p_dev_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && state == S_DEV && bitcnt == 4'd8 && !dev_hit) |=> (state == S_IDLE && !sda_oe));

  p_page_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR && $past(state) == S_WR) |-> ptr[AW-1:PW] == $past(ptr[AW-1:PW]));

  p_busy_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  p_rd_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD && $past(state) == S_RD && ptr != $past(ptr)) |-> ptr == $past(ptr) + 1'b1);

  p_wp_no_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp_i));
endmodule

// File: tb/sim_i2c_eeprom_slave.sv
module sim_i2c_eeprom_slave;
  localparam int CLK_P = 10;
  localparam int T     = 4;
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;
  localparam int BUSY  = 300;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe, sda_line;
  int checks = 0, errors = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] exp_q [$];
  logic [7:0] act_q [$];
  string      tag_q [$];

  assign sda_line = sda_m & ~sda_oe;
  always #(CLK_P/2) clk = ~clk;

  i2c_eeprom_slave #(.AW(AW), .PW(6), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap(strap), .wp_i(wp));

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  always @(negedge clk)
    while (act_q.size() > 0 && exp_q.size() > 0)
      check(tag_q.pop_front(), {24'd0, act_q.pop_front()}, {24'd0, exp_q.pop_front()});

  task automatic tick(); repeat (T) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1; tick(); scl_m = 1; tick(); sda_m = 0; tick(); scl_m = 0; tick();
  endtask

  task automatic i2c_stop();
    sda_m = 0; tick(); scl_m = 1; tick(); sda_m = 1; tick(); tick();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(); scl_m = 1; tick(); scl_m = 0; tick();
    end
    sda_m = 1; tick(); scl_m = 1; tick(); ack = ~sda_line; scl_m = 0; tick();
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(); scl_m = 1; tick(); b[i] = sda_line; scl_m = 0;
    end
    tick(); sda_m = ~mack; tick(); scl_m = 1; tick(); scl_m = 0; tick(); sda_m = 1;
  endtask

  function automatic logic [7:0] dev(input logic rw);
    return {4'b1010, strap, rw};
  endfunction

  task automatic addr_write(input logic [14:0] a, output logic ok);
    logic k;
    i2c_start(); put_byte(dev(1'b0), k); ok = k;
    put_byte({1'b0, a[14:8]}, k); ok &= k;
    put_byte(a[7:0], k); ok &= k;
  endtask

  task automatic wait_ready(output int nk, output logic ok);
    logic k;
    nk = 0; ok = 0;
    for (int i = 0; i < 40; i++) begin
      i2c_start(); put_byte(dev(1'b0), k); i2c_stop();
      if (k) begin ok = 1; break; end
      nk++;
    end
  endtask

  task automatic write_seq(input logic [14:0] a, input int n, input logic [7:0] seed, input string r);
    logic ok, k, rdy;
    logic [7:0] d;
    int nk;
    addr_write(a, ok);
    for (int i = 0; i < n; i++) begin
      d = seed + 8'(i * 3);
      put_byte(d, k); ok &= k;
      model[{a[AW-1:6], 6'(int'(a[5:0]) + i)}] = d;
    end
    check({r, " R3 acks"}, {31'd0, ok}, 1);
    i2c_stop();
    wait_ready(nk, rdy);
    check({r, " R6 busy nack"}, {31'd0, nk > 0}, 1);
    check({r, " R6 ready ack"}, {31'd0, rdy}, 1);
  endtask

  task automatic read_body(input int first, input int n, input string r);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[(first + i) % DEPTH]);
      tag_q.push_back(r);
      get_byte(i != n - 1, b);
      act_q.push_back(b);
    end
    i2c_stop();
  endtask

  task automatic read_seq(input logic [14:0] a, input int n, input string r);
    logic ok, k;
    addr_write(a, ok);
    i2c_start(); put_byte(dev(1'b1), k);
    check({r, " R7 addr acks"}, {31'd0, ok & k}, 1);
    read_body(int'(a[AW-1:0]), n, r);
  endtask

  task automatic cur_read(input int first, input int n, input string r);
    logic k;
    i2c_start(); put_byte(dev(1'b1), k);
    check({r, " R7 dev ack"}, {31'd0, k}, 1);
    read_body(first, n, r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R3 reset sda_oe", {31'd0, sda_oe}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
  end

  initial begin : main
    logic k, ok;
    int nk;
    repeat (8) @(negedge clk);

    i2c_start(); put_byte({4'b1010, 3'b010, 1'b0}, k); i2c_stop();
    check("R2 strap mismatch nack", {31'd0, k}, 0);
    i2c_start(); put_byte({4'b1011, strap, 1'b0}, k); i2c_stop();
    check("R2 type nibble nack", {31'd0, k}, 0);
    i2c_start(); put_byte(dev(1'b0), k); i2c_stop();
    check("R1 R2 start after stop acked", {31'd0, k}, 1);

    write_seq(15'h0100, 64, 8'h10, "fill p4");
    write_seq(15'h013C, 8, 8'hC0, "R5 wrap");
    read_seq(15'h0100, 64, "R5 page wrap read");

    write_seq(15'h0140, 66, 8'h40, "R5 overflow");
    read_seq(15'h0140, 64, "R5 overflow read");

    write_seq(15'h0123, 1, 8'h5A, "R4 low");
    write_seq(15'h0523, 1, 8'hA5, "R4 high");
    read_seq(15'h0523, 1, "R4 high byte used");
    read_seq(15'h0123, 1, "R7 random read");
    cur_read(16'h124, 1, "R7 current read");

    write_seq(15'h07FE, 2, 8'h70, "R8 end");
    write_seq(15'h0000, 3, 8'h80, "R8 start");
    read_seq(15'h07FE, 4, "R8 array wrap");
    cur_read(2, 1, "R8 pointer after nack");

    wp = 1;
    addr_write(15'h0123, ok);
    put_byte(8'hEE, k);
    check("R9 protected data acked", {31'd0, ok & k}, 1);
    i2c_stop();
    i2c_start(); put_byte(dev(1'b0), k); i2c_stop();
    check("R9 no busy window", {31'd0, k}, 1);
    wp = 0;
    read_seq(15'h0123, 1, "R9 data unchanged");

    addr_write(15'h0130, ok); i2c_stop();
    i2c_start(); put_byte(dev(1'b0), k); i2c_stop();
    check("R10 no busy after address-only", {31'd0, k}, 1);
    read_seq(15'h0130, 1, "R10 data unchanged");
    wait_ready(nk, ok);
    check("R10 ready at once", nk, 0);

    repeat (4) @(negedge clk);
    check("queue drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule